// File: doc/BRIEF.md
# Translation Unit Control and Fault Register Block

This block is the software-visible control face of an address translation unit. It sits on a simple 32-bit register bus with 12-bit byte offsets. Software uses it to switch the unit on or off, to ask it to pause (the blocked state) and to set the base of the translation table. It also issues two kinds of translation-cache invalidation: all entries at once, or the entry of a single 4 KB page. The block turns these writes into level and pulse signals for the translation datapath. That datapath is a separate block.

In the other direction, the datapath reports faults as a one-cycle event that carries a 3-bit type code and the faulting address. The block records each fault as a pending interrupt bit and stores the address in one of four capture registers chosen by the fault's class. It drives an interrupt line whenever any bit is pending. A fault also forces the unit into the blocked state. The unit stays blocked until software writes the enable code again.

The control logic is a four-state machine:
- OFF: the reset state.
- RUN: enabled and translating.
- DRAIN: a block has been requested and the datapath has not yet confirmed it.
- HALT: blocked and confirmed.

The transitions are:
- Any state to RUN on an enable write.
- Any state to OFF on a disable write.
- RUN to DRAIN on a block write.
- DRAIN to HALT when the datapath acknowledges.
- RUN, DRAIN or HALT to HALT on a fault.
A fault takes priority over a control write in the same cycle.

Top module: `xlat_ctrl_regs`

## Requirements
- R1: After reset:
  - The control, status, table base, interrupt status and all four fault address registers read 0.
  - `xl_enable`, `xl_block`, `irq` and both flush strobes are low.
- R2: Writing 0x0000_0005 to offset 0x000 sets `xl_enable` high and `xl_block` low, and the control register then reads 5. Writing 0x0000_0000 returns the unit to OFF with all outputs low, and the control register reads 0. Any other value written to 0x000 changes nothing. A block request (0x0000_0007) made while OFF is also ignored.
- R3: Writing 0x0000_0007 while RUN raises `xl_block`, and the control register reads 7. Status bit 0 at offset 0x008 stays 0 until `xl_block_ack` is seen high at a clock edge. From the next cycle on, status bit 0 reads 1.
- R4: A fault event (`flt_valid` high at a clock edge) while the unit is not OFF has these effects from the next cycle on:
  - Interrupt status bit `flt_type` at offset 0x018 is set. The bit meanings are: 0 page fault, 1 read multi-hit, 2 write multi-hit, 3 bus error, 4 read security, 5 read access, 6 write security, 7 write access.
  - The unit is in HALT: `xl_block` is high and status bit 0 is 1.
  - It stays in HALT until the enable code is written.
  A fault event while the unit is OFF is ignored.
- R5: An accepted fault stores `flt_addr` into the capture register for its class. Type 0 goes to 0x024. Types 2, 6 and 7 go to 0x028. Types 1, 4 and 5 go to 0x02C. Type 3 goes to 0x030. The other capture registers keep their values.
- R6: Writing a mask to 0x01C clears each interrupt status bit whose mask bit is 1. If a bit is set by a fault in the same cycle as it is cleared, the set wins. Offset 0x01C reads 0.
- R7: `irq` is high exactly when at least one interrupt status bit is pending.
- R8: A write to 0x00C with bit 0 set drives `xl_flush_all` high for the single cycle after the write. A write with bit 0 clear produces no pulse.
- R9: A write to 0x010 with bit 0 set drives `xl_flush_page` high for the single cycle after the write, with `xl_flush_page_num` equal to write data bits [31:12]. A write with bit 0 clear produces no pulse.
- R10: Offset 0x014 holds the table base, which is aligned to 16 KB. Bits [13:0] read 0 and are driven as 0 on `xl_table_base`. The other bits keep the written value.
- R11: Offset 0x034 reads 0x3000_0000. Every other offset not named in these requirements reads 0. Writes to the status, interrupt status, capture and version registers have no effect.
- R12: A fault and a control write in the same cycle always leave the unit in HALT, even when the write is the enable or disable code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_rd_en | input | 1 | Register read strobe; read data is 0 when low |
| reg_addr | input | 12 | Byte offset of the access |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational from the offset |
| xl_enable | output | 1 | Unit enabled (any state but OFF) |
| xl_block | output | 1 | Block requested or held (DRAIN or HALT) |
| xl_block_ack | input | 1 | Datapath confirms it has reached the blocked state |
| xl_flush_all | output | 1 | One-cycle pulse: invalidate the whole translation cache |
| xl_flush_page | output | 1 | One-cycle pulse: invalidate one page entry |
| xl_flush_page_num | output | 20 | Page number for `xl_flush_page` |
| xl_table_base | output | 32 | Translation table base |
| flt_valid | input | 1 | Fault event strobe |
| flt_type | input | 3 | Fault type code (the bit index from R4) |
| flt_addr | input | 32 | Faulting address |
| irq | output | 1 | Interrupt, high while any fault bit is pending |

## Verification
Two pairs of events can land on the same clock edge.

The first pair is a fault and a software control write. The bench raises `flt_valid` in the same cycle as a write of the enable code, and again with a write of the disable code. It then requires status bit 0 to read 1 with `xl_block` high.

The second pair is a fault setting an interrupt bit and a clear write to that same bit. The bench issues both on one edge and expects the bit to survive. In the same cycle it clears an unrelated pending bit, which must go to 0.

// File: rtl/xlat_regs_pkg.sv
package xlat_regs_pkg;

    localparam int FTYPE_W   = 3;
    localparam int NUM_FAULT = 1 << FTYPE_W;

    localparam logic [11:0] OFS_CTRL      = 12'h000;
    localparam logic [11:0] OFS_STAT      = 12'h008;
    localparam logic [11:0] OFS_FLUSH_ALL = 12'h00C;
    localparam logic [11:0] OFS_FLUSH_PG  = 12'h010;
    localparam logic [11:0] OFS_TBASE     = 12'h014;
    localparam logic [11:0] OFS_ISTAT     = 12'h018;
    localparam logic [11:0] OFS_ICLR      = 12'h01C;
    localparam logic [11:0] OFS_FA_PAGE   = 12'h024;
    localparam logic [11:0] OFS_FA_WR     = 12'h028;
    localparam logic [11:0] OFS_FA_RD     = 12'h02C;
    localparam logic [11:0] OFS_FA_BUS    = 12'h030;
    localparam logic [11:0] OFS_VER       = 12'h034;

    localparam logic [31:0] CODE_OFF  = 32'h0000_0000;
    localparam logic [31:0] CODE_RUN  = 32'h0000_0005;
    localparam logic [31:0] CODE_HOLD = 32'h0000_0007;

    typedef enum logic [1:0] {
        ST_OFF   = 2'd0,
        ST_RUN   = 2'd1,
        ST_DRAIN = 2'd2,
        ST_HALT  = 2'd3
    } xlat_state_e;

    typedef enum logic [1:0] {
        FC_PAGE = 2'd0,
        FC_RD   = 2'd1,
        FC_WR   = 2'd2,
        FC_BUS  = 2'd3
    } fault_class_e;

    function automatic fault_class_e class_of(input logic [FTYPE_W-1:0] t);
        case (t)
            3'd0:              return FC_PAGE;
            3'd3:              return FC_BUS;
            3'd1, 3'd4, 3'd5:  return FC_RD;
            default:           return FC_WR;
        endcase
    endfunction

endpackage

// File: rtl/xlat_ctl_fsm.sv
module xlat_ctl_fsm
    import xlat_regs_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_wr,
    input  logic [DATA_W-1:0] cmd_val,
    input  logic              ack_in,
    input  logic              fault_in,
    output logic              enable_o,
    output logic              block_o,
    output logic              halted_o,
    output logic [2:0]        ctrl_code_o
);

    xlat_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        if (fault_in && state_q != ST_OFF)
            state_d = ST_HALT;
        else if (cmd_wr && cmd_val == DATA_W'(CODE_RUN))
            state_d = ST_RUN;
        else if (cmd_wr && cmd_val == DATA_W'(CODE_OFF))
            state_d = ST_OFF;
        else if (cmd_wr && cmd_val == DATA_W'(CODE_HOLD) && state_q == ST_RUN)
            state_d = ST_DRAIN;
        else if (state_q == ST_DRAIN && ack_in)
            state_d = ST_HALT;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_OFF;
        else        state_q <= state_d;
    end

    always_comb begin
        unique case (state_q)
            ST_OFF: begin
                enable_o = 1'b0; block_o = 1'b0; halted_o = 1'b0; ctrl_code_o = 3'd0;
            end
            ST_RUN: begin
                enable_o = 1'b1; block_o = 1'b0; halted_o = 1'b0; ctrl_code_o = 3'd5;
            end
            ST_DRAIN: begin
                enable_o = 1'b1; block_o = 1'b1; halted_o = 1'b0; ctrl_code_o = 3'd7;
            end
            ST_HALT: begin
                enable_o = 1'b1; block_o = 1'b1; halted_o = 1'b1; ctrl_code_o = 3'd7;
            end
            default: begin
                enable_o = 1'b0; block_o = 1'b0; halted_o = 1'b0; ctrl_code_o = 3'd0;
            end
        endcase
    end

    // R4 / R12: an accepted fault always lands in HALT
    a_r4_fault_halts: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_in && state_q != ST_OFF) |=> (state_q == ST_HALT));

    // R3: HALT is only entered through an acknowledge or a fault
    a_r3_halt_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(halted_o) |-> $past(ack_in || fault_in));

    // R2: OFF never asserts the block output
    a_r2_off_no_block: assert property (@(posedge clk) disable iff (!rst_n)
        !enable_o |-> !block_o);

    // R2: an enable write without a fault gives RUN
    a_r2_enable_runs: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && cmd_val == DATA_W'(CODE_RUN) && !fault_in) |=> (enable_o && !block_o));

endmodule

// File: rtl/xlat_fault_log.sv
module xlat_fault_log
    import xlat_regs_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 fault_ok,
    input  logic [FTYPE_W-1:0]   fault_type,
    input  logic [DATA_W-1:0]    fault_addr,
    input  logic                 clr_wr,
    input  logic [NUM_FAULT-1:0] clr_mask,
    output logic [NUM_FAULT-1:0] istat_o,
    output logic [DATA_W-1:0]    fa_page_o,
    output logic [DATA_W-1:0]    fa_rd_o,
    output logic [DATA_W-1:0]    fa_wr_o,
    output logic [DATA_W-1:0]    fa_bus_o,
    output logic                 irq_o
);

    for (genvar i = 0; i < NUM_FAULT; i++) begin : g_bit
        logic set_i;
        assign set_i = fault_ok && (fault_type == FTYPE_W'(i));
        always_ff @(posedge clk) begin
            if (!rst_n)                     istat_o[i] <= 1'b0;
            else if (set_i)                 istat_o[i] <= 1'b1;
            else if (clr_wr && clr_mask[i]) istat_o[i] <= 1'b0;
        end
    end

    fault_class_e cls;
    assign cls = class_of(fault_type);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fa_page_o <= '0;
            fa_rd_o   <= '0;
            fa_wr_o   <= '0;
            fa_bus_o  <= '0;
        end else if (fault_ok) begin
            unique case (cls)
                FC_PAGE: fa_page_o <= fault_addr;
                FC_RD:   fa_rd_o   <= fault_addr;
                FC_WR:   fa_wr_o   <= fault_addr;
                FC_BUS:  fa_bus_o  <= fault_addr;
                default: ;
            endcase
        end
    end

    assign irq_o = |istat_o;

    // R4: the bit named by the fault type is pending afterwards
    a_r4_bit_set: assert property (@(posedge clk) disable iff (!rst_n)
        fault_ok |=> istat_o[$past(fault_type)]);

    // R6: cleared bits drop when no fault sets anything that cycle
    a_r6_clear_takes: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_wr && !fault_ok) |=> ((istat_o & $past(clr_mask)) == '0));

    // R5: bus errors land in their own capture register
    a_r5_bus_capture: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_ok && fault_type == 3'd3) |=> (fa_bus_o == $past(fault_addr)));

endmodule

// File: rtl/xlat_flush_strobe.sv
module xlat_flush_strobe #(
    parameter int DATA_W     = 32,
    parameter int PAGE_SHIFT = 12
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         all_wr,
    input  logic                         pg_wr,
    input  logic [DATA_W-1:0]            wdata,
    output logic                         flush_all_o,
    output logic                         flush_pg_o,
    output logic [DATA_W-PAGE_SHIFT-1:0] flush_num_o
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flush_all_o <= 1'b0;
            flush_pg_o  <= 1'b0;
            flush_num_o <= '0;
        end else begin
            flush_all_o <= all_wr && wdata[0];
            flush_pg_o  <= pg_wr && wdata[0];
            if (pg_wr && wdata[0])
                flush_num_o <= wdata[DATA_W-1:PAGE_SHIFT];
        end
    end

    // R8: a full flush pulse only follows a qualifying write
    a_r8_flush_cause: assert property (@(posedge clk) disable iff (!rst_n)
        flush_all_o |-> $past(all_wr && wdata[0]));

    // R9: a page flush pulse only follows a qualifying write, with its page
    a_r9_page_cause: assert property (@(posedge clk) disable iff (!rst_n)
        flush_pg_o |-> ($past(pg_wr && wdata[0]) &&
                        flush_num_o == $past(wdata[DATA_W-1:PAGE_SHIFT])));

endmodule

// File: rtl/xlat_ctrl_regs.sv
module xlat_ctrl_regs
    import xlat_regs_pkg::*;
#(
    parameter int DATA_W     = 32,
    parameter int ADDR_W     = 12,
    parameter int PAGE_SHIFT = 12,
    parameter int BASE_ALIGN = 14,
    parameter int VER_MAJOR  = 3
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         reg_wr_en,
    input  logic                         reg_rd_en,
    input  logic [ADDR_W-1:0]            reg_addr,
    input  logic [DATA_W-1:0]            reg_wdata,
    output logic [DATA_W-1:0]            reg_rdata,
    output logic                         xl_enable,
    output logic                         xl_block,
    input  logic                         xl_block_ack,
    output logic                         xl_flush_all,
    output logic                         xl_flush_page,
    output logic [DATA_W-PAGE_SHIFT-1:0] xl_flush_page_num,
    output logic [DATA_W-1:0]            xl_table_base,
    input  logic                         flt_valid,
    input  logic [FTYPE_W-1:0]           flt_type,
    input  logic [DATA_W-1:0]            flt_addr,
    output logic                         irq
);

    localparam logic [DATA_W-1:0] BASE_MASK = ~((DATA_W'(1) << BASE_ALIGN) - DATA_W'(1));
    localparam logic [DATA_W-1:0] VER_WORD  = DATA_W'(VER_MAJOR) << (DATA_W - 4);

    logic wr_ctrl, wr_fall, wr_fpg, wr_tbase, wr_iclr;
    assign wr_ctrl  = reg_wr_en && reg_addr == ADDR_W'(OFS_CTRL);
    assign wr_fall  = reg_wr_en && reg_addr == ADDR_W'(OFS_FLUSH_ALL);
    assign wr_fpg   = reg_wr_en && reg_addr == ADDR_W'(OFS_FLUSH_PG);
    assign wr_tbase = reg_wr_en && reg_addr == ADDR_W'(OFS_TBASE);
    assign wr_iclr  = reg_wr_en && reg_addr == ADDR_W'(OFS_ICLR);

    logic                 halted;
    logic [2:0]           ctrl_code;
    logic                 fault_ok;
    logic [NUM_FAULT-1:0] istat;
    logic [DATA_W-1:0]    fa_page, fa_rd, fa_wr, fa_bus;
    logic [DATA_W-1:0]    tbase_q;

    xlat_ctl_fsm #(.DATA_W(DATA_W)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_wr     (wr_ctrl),
        .cmd_val    (reg_wdata),
        .ack_in     (xl_block_ack),
        .fault_in   (flt_valid),
        .enable_o   (xl_enable),
        .block_o    (xl_block),
        .halted_o   (halted),
        .ctrl_code_o(ctrl_code)
    );

    assign fault_ok = flt_valid && xl_enable;

    xlat_fault_log #(.DATA_W(DATA_W)) u_flog (
        .clk       (clk),
        .rst_n     (rst_n),
        .fault_ok  (fault_ok),
        .fault_type(flt_type),
        .fault_addr(flt_addr),
        .clr_wr    (wr_iclr),
        .clr_mask  (reg_wdata[NUM_FAULT-1:0]),
        .istat_o   (istat),
        .fa_page_o (fa_page),
        .fa_rd_o   (fa_rd),
        .fa_wr_o   (fa_wr),
        .fa_bus_o  (fa_bus),
        .irq_o     (irq)
    );

    xlat_flush_strobe #(.DATA_W(DATA_W), .PAGE_SHIFT(PAGE_SHIFT)) u_flush (
        .clk        (clk),
        .rst_n      (rst_n),
        .all_wr     (wr_fall),
        .pg_wr      (wr_fpg),
        .wdata      (reg_wdata),
        .flush_all_o(xl_flush_all),
        .flush_pg_o (xl_flush_page),
        .flush_num_o(xl_flush_page_num)
    );

    always_ff @(posedge clk) begin
        if (!rst_n)        tbase_q <= '0;
        else if (wr_tbase) tbase_q <= reg_wdata & BASE_MASK;
    end
    assign xl_table_base = tbase_q;

    always_comb begin
        reg_rdata = '0;
        if (reg_rd_en) begin
            case (reg_addr)
                ADDR_W'(OFS_CTRL):    reg_rdata = DATA_W'(ctrl_code);
                ADDR_W'(OFS_STAT):    reg_rdata = DATA_W'(halted);
                ADDR_W'(OFS_TBASE):   reg_rdata = tbase_q;
                ADDR_W'(OFS_ISTAT):   reg_rdata = DATA_W'(istat);
                ADDR_W'(OFS_FA_PAGE): reg_rdata = fa_page;
                ADDR_W'(OFS_FA_WR):   reg_rdata = fa_wr;
                ADDR_W'(OFS_FA_RD):   reg_rdata = fa_rd;
                ADDR_W'(OFS_FA_BUS):  reg_rdata = fa_bus;
                ADDR_W'(OFS_VER):     reg_rdata = VER_WORD;
                default:              reg_rdata = '0;
            endcase
        end
    end

    // R10: the table base never carries bits below its alignment
    a_r10_base_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        (xl_table_base & ~BASE_MASK) == '0);

    // R7: the interrupt line goes up after an accepted fault
    a_r7_irq_after_fault: assert property (@(posedge clk) disable iff (!rst_n)
        fault_ok |=> irq);

endmodule

// File: tb/xlat_ctrl_regs_tb_top.sv
`timescale 1ns/1ps
module xlat_ctrl_regs_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr_en = 1'b0, reg_rd_en = 1'b0;
    logic [11:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0, reg_rdata;
    logic        xl_enable, xl_block, xl_block_ack = 1'b0;
    logic        xl_flush_all, xl_flush_page;
    logic [19:0] xl_flush_page_num;
    logic [31:0] xl_table_base;
    logic        flt_valid = 1'b0;
    logic [2:0]  flt_type = '0;
    logic [31:0] flt_addr = '0;
    logic        irq;

    int checks = 0, failures = 0;

    always #4 clk = ~clk;

    xlat_ctrl_regs dut_i (
        .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_rd_en(reg_rd_en),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .xl_enable(xl_enable), .xl_block(xl_block), .xl_block_ack(xl_block_ack),
        .xl_flush_all(xl_flush_all), .xl_flush_page(xl_flush_page),
        .xl_flush_page_num(xl_flush_page_num), .xl_table_base(xl_table_base),
        .flt_valid(flt_valid), .flt_type(flt_type), .flt_addr(flt_addr), .irq(irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        reg_rd_en = 1'b1; reg_addr = a;
        #1 d = reg_rdata;
        reg_rd_en = 1'b0;
    endtask

    task automatic rdchk(input string req, input logic [11:0] a, input logic [31:0] exp);
        logic [31:0] v;
        rd(a, v);
        check(req, v, exp);
    endtask

    task automatic fault(input logic [2:0] t, input logic [31:0] a);
        @(negedge clk);
        flt_valid = 1'b1; flt_type = t; flt_addr = a;
        @(negedge clk);
        flt_valid = 1'b0;
    endtask

    function automatic logic [11:0] fa_ofs(input int t);
        if (t == 0) return 12'h024;
        if (t == 3) return 12'h030;
        if (t == 1 || t == 4 || t == 5) return 12'h02C;
        return 12'h028;
    endfunction

    function automatic int fa_idx(input int t);
        if (t == 0) return 0;
        if (t == 3) return 3;
        if (t == 1 || t == 4 || t == 5) return 1;
        return 2;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [31:0] exp_fa [4];
        logic [31:0] a;
        for (int k = 0; k < 4; k++) exp_fa[k] = '0;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        check("R1 enable", 32'(xl_enable), 0);
        check("R1 block", 32'(xl_block), 0);
        check("R1 irq", 32'(irq), 0);
        check("R1 flushes", 32'({xl_flush_all, xl_flush_page}), 0);
        check("R1 base port", xl_table_base, 0);

        // R11 / R1: full offset sweep after reset
        for (int w = 0; w < 1024; w++) begin
            logic [11:0] o = 12'(w * 4);
            rdchk("R11 sweep", o, (o == 12'h034) ? 32'h3000_0000 : 32'h0);
        end
        rdchk("R11 unaligned", 12'h035, 0);
        wr(12'h034, 32'hFFFF_FFFF);
        wr(12'h018, 32'hFFFF_FFFF);
        wr(12'h024, 32'h1234_5678);
        wr(12'h008, 32'h1);
        rdchk("R11 version ro", 12'h034, 32'h3000_0000);
        rdchk("R11 istat ro", 12'h018, 0);
        rdchk("R11 fa ro", 12'h024, 0);
        rdchk("R11 stat ro", 12'h008, 0);

        // R4: fault while OFF ignored
        fault(3'd0, 32'hDEAD_0000);
        rdchk("R4 off istat", 12'h018, 0);
        rdchk("R4 off fa", 12'h024, 0);
        check("R4 off irq", 32'(irq), 0);

        // R2: control codes
        wr(12'h000, 32'h7);
        check("R2 hold in off", 32'(xl_block), 0);
        rdchk("R2 hold in off ctrl", 12'h000, 0);
        wr(12'h000, 32'h5);
        check("R2 enable", 32'({xl_enable, xl_block}), 32'b10);
        rdchk("R2 ctrl run", 12'h000, 5);
        wr(12'h000, 32'h3);
        rdchk("R2 bad code", 12'h000, 5);
        wr(12'h000, 32'h105);
        rdchk("R2 bad code wide", 12'h000, 5);
        wr(12'h000, 32'h0);
        check("R2 disable", 32'({xl_enable, xl_block}), 0);
        rdchk("R2 ctrl off", 12'h000, 0);

        // R3: block handshake
        wr(12'h000, 32'h5);
        wr(12'h000, 32'h7);
        check("R3 block out", 32'(xl_block), 1);
        rdchk("R3 ctrl hold", 12'h000, 7);
        for (int c = 0; c < 3; c++) begin
            rdchk("R3 no ack", 12'h008, 0);
            @(negedge clk);
        end
        xl_block_ack = 1'b1;
        @(negedge clk);
        xl_block_ack = 1'b0;
        rdchk("R3 acked", 12'h008, 1);
        wr(12'h000, 32'h5);
        rdchk("R3 released", 12'h008, 0);
        check("R3 block low", 32'(xl_block), 0);

        // R10: table base
        wr(12'h014, 32'hFFFF_FFFF);
        rdchk("R10 base ones", 12'h014, 32'hFFFF_C000);
        check("R10 base port", xl_table_base, 32'hFFFF_C000);
        wr(12'h014, 32'h1234_5678);
        rdchk("R10 base pattern", 12'h014, 32'h1234_4000);

        // R8: full flush pulse
        wr(12'h00C, 32'h1);
        check("R8 pulse", 32'(xl_flush_all), 1);
        @(negedge clk);
        check("R8 one cycle", 32'(xl_flush_all), 0);
        wr(12'h00C, 32'h2);
        check("R8 no pulse", 32'(xl_flush_all), 0);

        // R9: page flush pulse
        wr(12'h010, 32'hABCD_E001);
        check("R9 pulse", 32'(xl_flush_page), 1);
        check("R9 page", 32'(xl_flush_page_num), 32'hABCDE);
        @(negedge clk);
        check("R9 one cycle", 32'(xl_flush_page), 0);
        wr(12'h010, 32'h1111_1000);
        check("R9 no pulse", 32'(xl_flush_page), 0);

        // R4 R5 R6 R7: sweep every fault type
        for (int t = 0; t < 8; t++) begin
            a = 32'hA000_0000 + 32'(t) * 32'h0101_0123;
            fault(3'(t), a);
            exp_fa[fa_idx(t)] = a;
            rdchk("R4 halted", 12'h008, 1);
            check("R4 block", 32'(xl_block), 1);
            rdchk("R4 istat bit", 12'h018, 32'h1 << t);
            check("R7 irq set", 32'(irq), 1);
            rdchk("R5 page reg", 12'h024, exp_fa[0]);
            rdchk("R5 read reg", 12'h02C, exp_fa[1]);
            rdchk("R5 write reg", 12'h028, exp_fa[2]);
            rdchk("R5 bus reg", 12'h030, exp_fa[3]);
            rdchk("R5 mapped", fa_ofs(t), a);
            wr(12'h01C, 32'h1 << t);
            rdchk("R6 cleared", 12'h018, 0);
            check("R7 irq clear", 32'(irq), 0);
            rdchk("R4 still halted", 12'h008, 1);
            wr(12'h000, 32'h5);
            rdchk("R4 re-enabled", 12'h008, 0);
        end

        // R6 R7: several pending
        fault(3'd1, 32'h0000_1000);
        fault(3'd6, 32'h0000_2000);
        rdchk("R6 two pending", 12'h018, 32'h42);
        wr(12'h01C, 32'h02);
        rdchk("R6 partial", 12'h018, 32'h40);
        check("R7 irq partial", 32'(irq), 1);
        rdchk("R6 iclr reads 0", 12'h01C, 0);
        wr(12'h01C, 32'h40);
        check("R7 irq none", 32'(irq), 0);
        wr(12'h000, 32'h5);

        // R6: set and clear same bit same cycle, clear other bit
        fault(3'd0, 32'h0000_3000);
        @(negedge clk);
        reg_wr_en = 1'b1; reg_addr = 12'h01C; reg_wdata = 32'h05;
        flt_valid = 1'b1; flt_type = 3'd2; flt_addr = 32'h0000_4000;
        @(negedge clk);
        reg_wr_en = 1'b0; flt_valid = 1'b0;
        rdchk("R6 set wins", 12'h018, 32'h04);
        wr(12'h01C, 32'hFF);
        wr(12'h000, 32'h5);

        // R12: fault against enable and disable writes
        @(negedge clk);
        reg_wr_en = 1'b1; reg_addr = 12'h000; reg_wdata = 32'h5;
        flt_valid = 1'b1; flt_type = 3'd3; flt_addr = 32'h0000_5000;
        @(negedge clk);
        reg_wr_en = 1'b0; flt_valid = 1'b0;
        rdchk("R12 vs enable", 12'h008, 1);
        check("R12 block", 32'(xl_block), 1);
        wr(12'h000, 32'h5);
        @(negedge clk);
        reg_wr_en = 1'b1; reg_addr = 12'h000; reg_wdata = 32'h0;
        flt_valid = 1'b1; flt_type = 3'd7; flt_addr = 32'h0000_6000;
        @(negedge clk);
        reg_wr_en = 1'b0; flt_valid = 1'b0;
        rdchk("R12 vs disable", 12'h008, 1);
        check("R12 enable kept", 32'(xl_enable), 1);
        rdchk("R12 addr", 12'h028, 32'h0000_6000);

        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule